// File: doc/BRIEF.md
# Dual-Pipe Warp Issue Scheduler

This block decides, clock by clock, which work enters each of the two execution pipelines of a SIMD shader core. One pipeline is an 8-lane multiply-add array. The other is a special-function pipeline that runs at a quarter of that rate. The core holds four warps of 32 lanes each. Every warp is split into four lane groups of 8 lanes, so the scheduler tracks 16 lane groups. Each group walks through the same short program independently. Because a 32-lane instruction is issued as separate 8-lane pieces, one warp instruction costs four multiply-add issues.

The program is a list of one-bit tokens. Software writes it through a small write port while the block is idle, then pulses `start` with a length. The two pipelines are arbitrated separately, so in a single clock a multiply-add from one group can go out next to a special-function issue from another group. Each token depends on the one before it. A group stays blocked after an issue until its operation has drained out of a fixed 4-stage pipeline.

When every group has retired its last token, the block pulses `done`. It also keeps two counters that a test harness can compare against a timing model. One counts total cycles. The other counts cycles in which the special-function pipe issued while the multiply-add array stayed empty.

Top module: `wsch_issue_sched`

## Requirements
- R1: While reset is asserted and after it is released, before any start, both issue strobes, `done` and `running` are low and both counters read zero.
- R2: A `start` pulse while idle captures `prog_len`, clears both counters and raises `running` from the next cycle. A `start` pulse while running has no effect.
- R3: The multiply-add pipe issues at most one lane group per clock, and only while running. Group number g appears as warp g/4 and lane group g%4.
- R4: A lane group issues its next token no earlier than 5 clocks after its previous issue: it is busy for 4 pipeline stages and is released at the edge where it leaves.
- R5: The special-function pipe issues at most once in any 4 consecutive clocks.
- R6: Both pipes may issue in the same clock, always for two different lane groups.
- R7: Each pipe grants round-robin. It searches upward from the group after its last grant, wrapping from 15 to 0, and the search restarts at group 0 on every start.
- R8: `done` is a single-cycle pulse. It rises one clock after the last group's last operation has left its pipeline. `running` falls in the same cycle, and no issue happens then.
- R9: `cycle_count` increments on every clock edge at which `running` was high, including the edge that raises `done`.
- R10: `bubble_count` increments on every clock in which the special-function pipe issues and the multiply-add pipe does not.
- R11: A token written as 0 at an address is a multiply-add op, and a token written as 1 is a special-function op. A program length of 0 completes with `done` one clock after start and a `cycle_count` of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_we | input | 1 | Token memory write strobe |
| tok_addr | input | 8 | Token index to write |
| tok_is_sfu | input | 1 | Token kind: 1 special-function, 0 multiply-add |
| prog_len | input | 9 | Program length in tokens, 0 to 256 |
| start | input | 1 | Start pulse |
| mad_issue | output | 1 | Multiply-add issue strobe |
| mad_warp | output | 2 | Warp of the multiply-add issue |
| mad_lane_grp | output | 2 | Lane group of the multiply-add issue |
| sfu_issue | output | 1 | Special-function issue strobe |
| sfu_warp | output | 2 | Warp of the special-function issue |
| sfu_lane_grp | output | 2 | Lane group of the special-function issue |
| done | output | 1 | Completion pulse |
| running | output | 1 | Program in progress |
| cycle_count | output | 32 | Cycles spent running |
| bubble_count | output | 32 | Cycles with special-function issue alone |

## Verification
The first issue is due one edge after the start edge. The bench's model advances on the same rising edge as the design, and every output is compared at the following falling edge, so each result is checked in the cycle it is due. Closed-form totals tie the count checks to the timing rules rather than to the model: `done` comes 5 clocks after the last issue, an all-multiply-add program of length L runs 16L+5 cycles, and an all-special-function program runs 64L+2 cycles. A separate per-group record of issue times checks the 5-clock spacing without relying on the model.

// File: rtl/wsch_pkg.sv
package wsch_pkg;

  // Kind of a program token as stored in token memory
  typedef enum logic {
    TOK_MAD = 1'b0,
    TOK_SFU = 1'b1
  } tok_kind_e;

endpackage

// File: rtl/wsch_rr_arb.sv
// Round-robin arbiter: the search starts at the slot after the last grant
module wsch_rr_arb #(
  parameter int N = 16,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [N-1:0]  req,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);

  logic [IW-1:0] ptr_q, ptr_d;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int k = 0; k < N; k++) begin
      if (!gnt_vld && req[(int'(ptr_q) + k) % N]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'((int'(ptr_q) + k) % N);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (clr) begin
      ptr_d = '0;
    end else if (gnt_vld) begin
      if (gnt_idx == IW'(N - 1)) ptr_d = '0;
      else                       ptr_d = gnt_idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

endmodule

// File: rtl/wsch_retire_pipe.sv
// Fixed-latency pipeline carrying the group id of each operation to its retirement
module wsch_retire_pipe #(
  parameter int DEPTH = 4,
  parameter int IDW   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           in_vld,
  input  logic [IDW-1:0] in_id,
  output logic           out_vld,
  output logic [IDW-1:0] out_id
);

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [IDW-1:0]   id_q [DEPTH];

  always_comb begin
    if (clr) vld_d = '0;
    else     vld_d = {vld_q[DEPTH-2:0], in_vld};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    id_q[0] <= in_id;
    for (int s = 1; s < DEPTH; s++) id_q[s] <= id_q[s-1];
  end

  assign out_vld = vld_q[DEPTH-1];
  assign out_id  = id_q[DEPTH-1];

endmodule

// File: rtl/wsch_scoreboard.sv
// Per-lane-group program counter and busy flag, plus the token store
module wsch_scoreboard
  import wsch_pkg::*;
#(
  parameter int N       = 16,
  parameter int MAX_LEN = 256,
  localparam int IW     = $clog2(N),
  localparam int PC_W   = $clog2(MAX_LEN + 1),
  localparam int ADDR_W = $clog2(MAX_LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [PC_W-1:0]   len,
  input  logic              tok_we,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic              tok_is_sfu,
  input  logic              mad_set,
  input  logic [IW-1:0]     mad_set_id,
  input  logic              sfu_set,
  input  logic [IW-1:0]     sfu_set_id,
  input  logic              ret_a,
  input  logic [IW-1:0]     ret_a_id,
  input  logic              ret_b,
  input  logic [IW-1:0]     ret_b_id,
  output logic [N-1:0]      mad_req,
  output logic [N-1:0]      sfu_req,
  output logic              all_done
);

  tok_kind_e  tok_q [MAX_LEN];
  logic [N-1:0] fin;

  always_ff @(posedge clk) begin
    if (tok_we) tok_q[tok_addr] <= tok_kind_e'(tok_is_sfu);
  end

  for (genvar g = 0; g < N; g++) begin : g_grp
    logic [PC_W-1:0] pc_q, pc_d;
    logic            busy_q, busy_d;
    logic            hit, ret, pending;
    tok_kind_e       kind;

    assign hit     = (mad_set && mad_set_id == IW'(g)) || (sfu_set && sfu_set_id == IW'(g));
    assign ret     = (ret_a && ret_a_id == IW'(g)) || (ret_b && ret_b_id == IW'(g));
    assign pending = pc_q < len;
    assign kind    = tok_q[pc_q[ADDR_W-1:0]];

    assign mad_req[g] = run && pending && !busy_q && (kind == TOK_MAD);
    assign sfu_req[g] = run && pending && !busy_q && (kind == TOK_SFU);
    assign fin[g]     = !pending && !busy_q;

    always_comb begin
      pc_d   = pc_q;
      busy_d = busy_q;
      if (clr) begin
        pc_d   = '0;
        busy_d = 1'b0;
      end else begin
        if (ret) busy_d = 1'b0;
        if (hit) begin
          busy_d = 1'b1;
          pc_d   = pc_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q   <= '0;
        busy_q <= 1'b0;
      end else begin
        pc_q   <= pc_d;
        busy_q <= busy_d;
      end
    end
  end

  assign all_done = &fin;

endmodule

// File: rtl/wsch_issue_sched.sv
// Top: two independently arbitrated issue pipes over a shared scoreboard
module wsch_issue_sched #(
  parameter int WARPS       = 4,
  parameter int WARP_LANES  = 32,
  parameter int ARRAY_LANES = 8,
  parameter int PIPE_DEPTH  = 4,
  parameter int SFU_II      = 4,
  parameter int MAX_LEN     = 256,
  parameter int CNT_W       = 32,
  localparam int GPW    = WARP_LANES / ARRAY_LANES,
  localparam int NGRP   = WARPS * GPW,
  localparam int GID_W  = $clog2(NGRP),
  localparam int WID_W  = $clog2(WARPS),
  localparam int LG_W   = $clog2(GPW),
  localparam int PC_W   = $clog2(MAX_LEN + 1),
  localparam int ADDR_W = $clog2(MAX_LEN),
  localparam int HOLD_W = $clog2(SFU_II)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tok_we,
  input  logic [ADDR_W-1:0] tok_addr,
  input  logic              tok_is_sfu,
  input  logic [PC_W-1:0]   prog_len,
  input  logic              start,
  output logic              mad_issue,
  output logic [WID_W-1:0]  mad_warp,
  output logic [LG_W-1:0]   mad_lane_grp,
  output logic              sfu_issue,
  output logic [WID_W-1:0]  sfu_warp,
  output logic [LG_W-1:0]   sfu_lane_grp,
  output logic              done,
  output logic              running,
  output logic [CNT_W-1:0]  cycle_count,
  output logic [CNT_W-1:0]  bubble_count
);

  logic              run_q, run_d;
  logic [PC_W-1:0]   len_q, len_d;
  logic [HOLD_W-1:0] hold_q, hold_d;
  logic [CNT_W-1:0]  cyc_q, cyc_d, bub_q, bub_d;
  logic              done_q, done_d;
  logic              mad_iss_q, mad_iss_d, sfu_iss_q, sfu_iss_d;
  logic [GID_W-1:0]  mad_gid_q, mad_gid_d, sfu_gid_q, sfu_gid_d;

  logic              start_go;
  logic [NGRP-1:0]   mad_req, sfu_req, sfu_req_gated;
  logic              mad_gv, sfu_gv, all_done;
  logic [GID_W-1:0]  mad_gi, sfu_gi;
  logic              ret_m, ret_s;
  logic [GID_W-1:0]  ret_m_id, ret_s_id;

  assign start_go      = start && !run_q;
  assign sfu_req_gated = (hold_q == '0) ? sfu_req : '0;

  wsch_scoreboard #(.N(NGRP), .MAX_LEN(MAX_LEN)) u_sb (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start_go),
    .run        (run_q),
    .len        (len_q),
    .tok_we     (tok_we),
    .tok_addr   (tok_addr),
    .tok_is_sfu (tok_is_sfu),
    .mad_set    (mad_gv),
    .mad_set_id (mad_gi),
    .sfu_set    (sfu_gv),
    .sfu_set_id (sfu_gi),
    .ret_a      (ret_m),
    .ret_a_id   (ret_m_id),
    .ret_b      (ret_s),
    .ret_b_id   (ret_s_id),
    .mad_req    (mad_req),
    .sfu_req    (sfu_req),
    .all_done   (all_done)
  );

  wsch_rr_arb #(.N(NGRP)) u_mad_arb (
    .clk(clk), .rst_n(rst_n), .clr(start_go),
    .req(mad_req), .gnt_vld(mad_gv), .gnt_idx(mad_gi)
  );

  wsch_rr_arb #(.N(NGRP)) u_sfu_arb (
    .clk(clk), .rst_n(rst_n), .clr(start_go),
    .req(sfu_req_gated), .gnt_vld(sfu_gv), .gnt_idx(sfu_gi)
  );

  wsch_retire_pipe #(.DEPTH(PIPE_DEPTH), .IDW(GID_W)) u_mad_pipe (
    .clk(clk), .rst_n(rst_n), .clr(start_go),
    .in_vld(mad_gv), .in_id(mad_gi), .out_vld(ret_m), .out_id(ret_m_id)
  );

  wsch_retire_pipe #(.DEPTH(PIPE_DEPTH), .IDW(GID_W)) u_sfu_pipe (
    .clk(clk), .rst_n(rst_n), .clr(start_go),
    .in_vld(sfu_gv), .in_id(sfu_gi), .out_vld(ret_s), .out_id(ret_s_id)
  );

  // next-state logic
  always_comb begin
    run_d     = run_q;
    len_d     = len_q;
    cyc_d     = cyc_q;
    bub_d     = bub_q;
    done_d    = 1'b0;
    hold_d    = (hold_q != '0) ? hold_q - 1'b1 : hold_q;
    mad_iss_d = mad_gv;
    sfu_iss_d = sfu_gv;
    mad_gid_d = mad_gv ? mad_gi : mad_gid_q;
    sfu_gid_d = sfu_gv ? sfu_gi : sfu_gid_q;
    if (sfu_gv) hold_d = HOLD_W'(SFU_II - 1);
    if (start_go) begin
      run_d  = 1'b1;
      len_d  = prog_len;
      cyc_d  = '0;
      bub_d  = '0;
      hold_d = '0;
    end else if (run_q) begin
      cyc_d = cyc_q + 1'b1;
      if (sfu_gv && !mad_gv) bub_d = bub_q + 1'b1;
      if (all_done) begin
        done_d = 1'b1;
        run_d  = 1'b0;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      len_q     <= '0;
      hold_q    <= '0;
      cyc_q     <= '0;
      bub_q     <= '0;
      done_q    <= 1'b0;
      mad_iss_q <= 1'b0;
      sfu_iss_q <= 1'b0;
      mad_gid_q <= '0;
      sfu_gid_q <= '0;
    end else begin
      run_q     <= run_d;
      len_q     <= len_d;
      hold_q    <= hold_d;
      cyc_q     <= cyc_d;
      bub_q     <= bub_d;
      done_q    <= done_d;
      mad_iss_q <= mad_iss_d;
      sfu_iss_q <= sfu_iss_d;
      mad_gid_q <= mad_gid_d;
      sfu_gid_q <= sfu_gid_d;
    end
  end

  assign mad_issue    = mad_iss_q;
  assign mad_warp     = mad_gid_q[GID_W-1:LG_W];
  assign mad_lane_grp = mad_gid_q[LG_W-1:0];
  assign sfu_issue    = sfu_iss_q;
  assign sfu_warp     = sfu_gid_q[GID_W-1:LG_W];
  assign sfu_lane_grp = sfu_gid_q[LG_W-1:0];
  assign done         = done_q;
  assign running      = run_q;
  assign cycle_count  = cyc_q;
  assign bubble_count = bub_q;

endmodule

// File: rtl/wsch_checker.sv
module wsch_checker #(
  parameter int WID_W = 2,
  parameter int LG_W  = 2,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mad_issue,
  input logic [WID_W-1:0] mad_warp,
  input logic [LG_W-1:0]  mad_lane_grp,
  input logic             sfu_issue,
  input logic [WID_W-1:0] sfu_warp,
  input logic [LG_W-1:0]  sfu_lane_grp,
  input logic             done,
  input logic             running,
  input logic [CNT_W-1:0] cycle_count,
  input logic [CNT_W-1:0] bubble_count
);

  // R3
  idle_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (!mad_issue && !sfu_issue));

  // R5
  sfu_gap1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfu_issue |=> !sfu_issue);

  // R5
  sfu_gap2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfu_issue |=> ##1 !sfu_issue);

  // R5
  sfu_gap3_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfu_issue |=> ##2 !sfu_issue);

  // R6
  coissue_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mad_issue && sfu_issue) |-> ({mad_warp, mad_lane_grp} != {sfu_warp, sfu_lane_grp}));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!running && !mad_issue && !sfu_issue));

  // R9
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (cycle_count == $past(cycle_count) + 1'b1));

  // R10
  bubble_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && sfu_issue && !mad_issue) |->
      (bubble_count == $past(bubble_count) + 1'b1));

endmodule

bind wsch_issue_sched wsch_checker #(.WID_W(WID_W), .LG_W(LG_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mad_issue    (mad_issue),
  .mad_warp     (mad_warp),
  .mad_lane_grp (mad_lane_grp),
  .sfu_issue    (sfu_issue),
  .sfu_warp     (sfu_warp),
  .sfu_lane_grp (sfu_lane_grp),
  .done         (done),
  .running      (running),
  .cycle_count  (cycle_count),
  .bubble_count (bubble_count)
);

// File: tb/wsch_issue_sched_test.sv
`timescale 1ns/1ps
module wsch_issue_sched_test;

  localparam int NG = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tok_we;
  logic [7:0]  tok_addr;
  logic        tok_is_sfu;
  logic [8:0]  prog_len;
  logic        start;
  logic        mad_issue, sfu_issue, done, running;
  logic [1:0]  mad_warp, mad_lane_grp, sfu_warp, sfu_lane_grp;
  logic [31:0] cycle_count, bubble_count;

  always #5 clk = ~clk;

  wsch_issue_sched uut (
    .clk(clk), .rst_n(rst_n), .tok_we(tok_we), .tok_addr(tok_addr),
    .tok_is_sfu(tok_is_sfu), .prog_len(prog_len), .start(start),
    .mad_issue(mad_issue), .mad_warp(mad_warp), .mad_lane_grp(mad_lane_grp),
    .sfu_issue(sfu_issue), .sfu_warp(sfu_warp), .sfu_lane_grp(sfu_lane_grp),
    .done(done), .running(running), .cycle_count(cycle_count),
    .bubble_count(bubble_count)
  );

  int checks = 0;
  int errors = 0;
  bit chk_en = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_tok [256];
  bit m_run;
  int m_len, m_gap, m_mptr, m_sptr, m_cyc, m_bub;
  int m_pc [NG];
  int m_left [NG];
  bit m_mad_iss, m_sfu_iss, m_done;
  int m_mad_gid, m_sfu_gid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_len = 0; m_gap = 0; m_mptr = 0; m_sptr = 0; m_cyc = 0; m_bub = 0;
      for (int g = 0; g < NG; g++) begin m_pc[g] = 0; m_left[g] = 0; end
      m_mad_iss = 0; m_sfu_iss = 0; m_done = 0; m_mad_gid = 0; m_sfu_gid = 0;
    end else begin
      m_mad_iss = 0; m_sfu_iss = 0; m_done = 0;
      if (m_run) begin
        bit fin;
        int mg, sg;
        fin = 1;
        for (int g = 0; g < NG; g++) if (m_pc[g] != m_len || m_left[g] != 0) fin = 0;
        m_cyc++;
        if (fin) begin
          m_done = 1;
          m_run = 0;
        end else begin
          mg = -1; sg = -1;
          for (int k = 0; k < NG; k++) begin
            int g;
            g = (m_mptr + k) % NG;
            if (mg < 0 && m_pc[g] < m_len && m_left[g] == 0 && !m_tok[m_pc[g]]) mg = g;
          end
          if (m_gap == 0)
            for (int k = 0; k < NG; k++) begin
              int g;
              g = (m_sptr + k) % NG;
              if (sg < 0 && m_pc[g] < m_len && m_left[g] == 0 && m_tok[m_pc[g]]) sg = g;
            end
          for (int g = 0; g < NG; g++) if (m_left[g] > 0) m_left[g]--;
          if (m_gap > 0) m_gap--;
          if (mg >= 0) begin
            m_left[mg] = 4; m_pc[mg]++; m_mptr = (mg + 1) % NG;
            m_mad_iss = 1; m_mad_gid = mg;
          end
          if (sg >= 0) begin
            m_left[sg] = 4; m_pc[sg]++; m_sptr = (sg + 1) % NG;
            m_sfu_iss = 1; m_sfu_gid = sg; m_gap = 3;
          end
          if (sg >= 0 && mg < 0) m_bub++;
        end
      end else if (start) begin
        m_run = 1; m_len = int'(prog_len); m_gap = 0; m_mptr = 0; m_sptr = 0;
        m_cyc = 0; m_bub = 0;
        for (int g = 0; g < NG; g++) begin m_pc[g] = 0; m_left[g] = 0; end
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  int tb_cyc = 0;
  int last_iss [NG];
  int coissue = 0;

  initial for (int g = 0; g < NG; g++) last_iss[g] = -100;

  always @(negedge clk) begin
    tb_cyc++;
    if (rst_n && chk_en) begin
      check(mad_issue == m_mad_iss, "R3", "mad_issue", mad_issue, m_mad_iss);
      if (m_mad_iss)
        check({mad_warp, mad_lane_grp} == 4'(m_mad_gid), "R7", "mad group", {mad_warp, mad_lane_grp}, m_mad_gid);
      check(sfu_issue == m_sfu_iss, "R5", "sfu_issue", sfu_issue, m_sfu_iss);
      if (m_sfu_iss)
        check({sfu_warp, sfu_lane_grp} == 4'(m_sfu_gid), "R7", "sfu group", {sfu_warp, sfu_lane_grp}, m_sfu_gid);
      check(done == m_done, "R8", "done", done, m_done);
      check(running == m_run, "R2", "running", running, m_run);
      check(cycle_count == 32'(m_cyc), "R9", "cycle_count", cycle_count, m_cyc);
      check(bubble_count == 32'(m_bub), "R10", "bubble_count", bubble_count, m_bub);
      if (mad_issue && sfu_issue) coissue++;
      if (mad_issue) begin
        int g;
        g = int'({mad_warp, mad_lane_grp});
        check(tb_cyc - last_iss[g] >= 5, "R4", "mad issue spacing", tb_cyc - last_iss[g], 5);
        last_iss[g] = tb_cyc;
      end
      if (sfu_issue) begin
        int g;
        g = int'({sfu_warp, sfu_lane_grp});
        check(tb_cyc - last_iss[g] >= 5, "R4", "sfu issue spacing", tb_cyc - last_iss[g], 5);
        last_iss[g] = tb_cyc;
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  // kind: 0 all MAD, 1 all SFU, 2 every third SFU, 3 first half MAD then SFU
  task automatic load_prog(input int kind, input int len);
    for (int i = 0; i < len; i++) begin
      bit t;
      case (kind)
        0: t = 0;
        1: t = 1;
        2: t = (i % 3 == 2);
        default: t = (i >= len / 2);
      endcase
      tok_we = 1; tok_addr = 8'(i); tok_is_sfu = t; m_tok[i] = t;
      @(negedge clk);
    end
    tok_we = 0;
  endtask

  task automatic pulse_start(input int len);
    prog_len = 9'(len);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(input int limit, output bit seen);
    int n;
    n = 0;
    seen = 0;
    while (!seen && n < limit) begin
      if (done) seen = 1;
      else begin @(negedge clk); n++; end
    end
  endtask

  // ---------------- main sequence ----------------
  initial begin
    bit seen;
    rst_n = 0; start = 0; tok_we = 0; tok_addr = '0; tok_is_sfu = 0; prog_len = '0;
    repeat (3) @(negedge clk);
    // R1: outputs while in reset
    check(!mad_issue && !sfu_issue && !done && !running, "R1", "strobes in reset", 
          {mad_issue, sfu_issue, done, running}, 0);
    rst_n = 1;
    @(negedge clk);
    check(cycle_count == 0 && bubble_count == 0, "R1", "counters after reset",
          cycle_count + bubble_count, 0);
    check(!running && !done, "R1", "idle after reset", running, 0);
    chk_en = 1;

    // R11: empty program
    pulse_start(0);
    wait_done(20, seen);
    check(seen, "R11", "done for empty program", seen, 1);
    check(cycle_count == 1, "R11", "cycles for empty program", cycle_count, 1);
    @(negedge clk);

    // R9: all multiply-add, length 8 -> 16*8+5 cycles
    load_prog(0, 8);
    pulse_start(8);
    wait_done(1000, seen);
    check(seen, "R8", "done all-mad", seen, 1);
    check(cycle_count == 133, "R9", "cycles all-mad", cycle_count, 133);
    check(bubble_count == 0, "R10", "bubbles all-mad", bubble_count, 0);
    @(negedge clk);
    check(!done && !running, "R8", "done single pulse", done, 0);

    // R10/R11: all special-function, length 4 -> 64*4+2 cycles, 64 bubbles
    coissue = 0;
    load_prog(1, 4);
    pulse_start(4);
    wait_done(2000, seen);
    check(seen, "R8", "done all-sfu", seen, 1);
    check(cycle_count == 258, "R9", "cycles all-sfu", cycle_count, 258);
    check(bubble_count == 64, "R10", "bubbles all-sfu", bubble_count, 64);
    check(coissue == 0, "R6", "no co-issue in all-sfu", coissue, 0);
    @(negedge clk);

    // R6/R2: mixed program with a start pulse during the run
    coissue = 0;
    load_prog(2, 12);
    pulse_start(12);
    repeat (30) @(negedge clk);
    pulse_start(3);
    wait_done(4000, seen);
    check(seen, "R2", "done after ignored start", seen, 1);
    check(coissue > 0, "R6", "co-issue observed", coissue, 1);
    @(negedge clk);

    // 128 multiply-add followed by 128 special-function tokens per group
    load_prog(3, 256);
    pulse_start(256);
    wait_done(20000, seen);
    check(seen, "R8", "done long program", seen, 1);
    check(cycle_count >= 32'(64 * 128), "R5", "long program bounded by sfu rate",
          cycle_count, 64 * 128);
    @(negedge clk);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule